// File: doc/BRIEF.md
# Coincidence Gating Decision Unit

This block decides, event by event, whether a detected event may be stored, by looking at an external gate signal that has already been conditioned and synchronised upstream. Each event is announced by a single-cycle store pulse. The unit produces a store strobe for memory group 1, a store strobe for memory group 2, and a busy flag. The busy flag is high while a decision is still waiting for the gate.

The unit supports five gating modes. In off mode the gate is ignored. In the two basic modes (coincidence and anti-coincidence) the unit waits for the gate through a programmable window before it decides. In the two combined modes the decision is immediate: it tests whether the store pulse overlaps the gate. Every event in a combined mode is also copied to group 2. The unit captures mode, polarity and window length when an event starts and holds them until that event's decision is complete. A store pulse that arrives while a decision is pending is dropped and counted in a saturating counter.

Top module: `coinc_gate_unit`

## Requirements
- R1: After reset, both strobes and busy are low and the lost-event count is zero.
- R2: Mode code 0 (off) ignores the gate. Each accepted store pulse raises only the group 1 strobe, for one cycle, in the cycle after the pulse.
- R3: When pol_i is 1 the gate is active while gate_i is high. When pol_i is 0 the gate is active while gate_i is low.
- R4: Mode code 1 (coincidence) raises the group 1 strobe only if the gate is active in the store cycle or in one of the next W cycles, where W = win_i. The strobe appears in the cycle after the first such active cycle. If the window expires with no active gate, no strobe is produced.
- R5: Mode code 2 (anti-coincidence) produces no strobe if the gate becomes active within that same window. If the gate stays inactive, the group 1 strobe appears in the cycle after the window's last cycle, that is W+1 cycles after the store pulse.
- R6: With W = 0, a basic-mode event is decided at the store pulse from the gate in that cycle, and busy never rises.
- R7: Busy is high from the cycle after the store pulse up to the cycle in which the decision's strobe would appear. No strobe is ever high while busy is high.
- R8: Mode code 3 (combined coincidence) raises the group 2 strobe for every accepted event in the next cycle. It raises the group 1 strobe at the same time only if the gate is active in the store cycle.
- R9: Mode code 4 (combined anti-coincidence) raises the group 2 strobe for every accepted event. It raises the group 1 strobe only if the gate is inactive in the store cycle.
- R10: A store pulse seen while busy is high produces no strobe. It increments lost_cnt_o, which saturates at 2^LOST_W-1.
- R11: Changes to mode_i, pol_i and win_i while busy is high do not affect the pending decision.
- R12: Mode codes 5 to 7 behave exactly as off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| store_i | input | 1 | One-cycle event store pulse |
| gate_i | input | 1 | Conditioned gate level |
| mode_i | input | 3 | Gating mode code |
| pol_i | input | 1 | Gate polarity, 1 = active-high |
| win_i | input | WIN_W | Wait window length in clock cycles |
| g1_stb_o | output | 1 | Group 1 store strobe |
| g2_stb_o | output | 1 | Group 2 store strobe |
| busy_o | output | 1 | Decision pending |
| lost_cnt_o | output | LOST_W | Saturating count of dropped store pulses |

## Verification
The gate's first active cycle can coincide with the window's last cycle. In that case a hit and a timeout compete at the same edge. The sweep places a one-cycle gate pulse at every offset from the store cycle to just past the window, for every window length tested, and requires the hit to win. A second collision comes from a store pulse that lands on the very edge where a pending decision completes. The lost-event test issues a store pulse on every cycle of the window and expects that last pulse to be counted as lost, not started as a new event.

// File: rtl/coinc_gate_pkg.sv
// Package: shared mode codes and helpers for the coincidence gating unit.
// Assumes mode codes above the defined range are treated as off.
package coinc_gate_pkg;

    typedef enum logic [2:0] {
        MODE_OFF     = 3'd0,
        MODE_COINC   = 3'd1,
        MODE_ANTI    = 3'd2,
        MODE_CB_CO   = 3'd3,
        MODE_CB_ANTI = 3'd4
    } gate_mode_t;

    // Map a raw code onto a defined mode; undefined codes fall back to off.
    function automatic gate_mode_t norm_mode(input logic [2:0] code);
        return (code > 3'd4) ? MODE_OFF : gate_mode_t'(code);
    endfunction

endpackage

// File: rtl/cg_polarity.sv
// Gate polarity stage: turns the raw gate level into an "active" flag.
// Assumes gate_i is already synchronous to clk.
module cg_polarity (
    input  logic gate_i,
    input  logic pol_i,
    output logic active_o
);
    // Select active-high or active-low interpretation.
    always_comb active_o = pol_i ? gate_i : ~gate_i;
endmodule

// File: rtl/cg_window.sv
// Wait-window down counter: loaded with the window length at event start,
// counts down once per pending cycle, flags the final window cycle.
// Assumes load is only asserted with a non-zero length.
module cg_window #(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIN_W-1:0] len_i,
    input  logic             run_i,
    output logic             last_o
);
    logic [WIN_W-1:0] cnt_q;

    // Load on event start, decrement while the decision is pending.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= len_i;
        else if (run_i && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Final cycle of the window.
    always_comb last_o = (cnt_q == WIN_W'(1));
endmodule

// File: rtl/cg_lost_ctr.sv
// Saturating counter of store pulses dropped while a decision is pending.
module cg_lost_ctr #(
    parameter int LOST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    output logic [LOST_W-1:0] cnt_o
);
    localparam logic [LOST_W-1:0] CMAX = '1;

    // Count up on each drop and hold at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (inc_i && cnt_o != CMAX)
            cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/coinc_gate_unit.sv
// Coincidence gating decision unit (top).
// Decides per store pulse whether to strobe memory group 1 and/or group 2.
// Basic modes wait up to win_i cycles for the gate; combined modes decide
// at the store pulse and always strobe group 2. Settings are captured at
// event start. Assumes store_i is a one-cycle pulse and gate_i is synchronous.
module coinc_gate_unit #(
    parameter int WIN_W  = 8,
    parameter int LOST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_i,
    input  logic              gate_i,
    input  logic [2:0]        mode_i,
    input  logic              pol_i,
    input  logic [WIN_W-1:0]  win_i,
    output logic              g1_stb_o,
    output logic              g2_stb_o,
    output logic              busy_o,
    output logic [LOST_W-1:0] lost_cnt_o
);
    import coinc_gate_pkg::*;

    typedef enum logic {ST_IDLE, ST_WAIT} st_t;

    st_t        st_q, st_d;
    gate_mode_t mode_q, mode_now;
    logic       pol_q, pol_sel, gate_act, win_last;
    logic       load, g1_d, g2_d;

    // Current mode code, with undefined codes folded to off.
    always_comb mode_now = norm_mode(mode_i);

    // Polarity follows the live input when idle and the captured one when waiting.
    always_comb pol_sel = (st_q == ST_WAIT) ? pol_q : pol_i;

    cg_polarity u_pol (
        .gate_i  (gate_i),
        .pol_i   (pol_sel),
        .active_o(gate_act)
    );

    cg_window #(.WIN_W(WIN_W)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(load),
        .len_i (win_i),
        .run_i (st_q == ST_WAIT),
        .last_o(win_last)
    );

    cg_lost_ctr #(.LOST_W(LOST_W)) u_lost (
        .clk  (clk),
        .rst_n(rst_n),
        .inc_i(store_i && st_q == ST_WAIT),
        .cnt_o(lost_cnt_o)
    );

    // Decision logic: next state, window load and strobe requests.
    always_comb begin
        st_d = st_q;
        load = 1'b0;
        g1_d = 1'b0;
        g2_d = 1'b0;
        if (st_q == ST_IDLE) begin
            if (store_i) begin
                unique case (mode_now)
                    MODE_COINC, MODE_ANTI: begin
                        if (gate_act || win_i == '0)
                            g1_d = (mode_now == MODE_COINC) ? gate_act : ~gate_act;
                        else begin
                            load = 1'b1;
                            st_d = ST_WAIT;
                        end
                    end
                    MODE_CB_CO: begin
                        g1_d = gate_act;
                        g2_d = 1'b1;
                    end
                    MODE_CB_ANTI: begin
                        g1_d = ~gate_act;
                        g2_d = 1'b1;
                    end
                    default: g1_d = 1'b1;
                endcase
            end
        end else begin
            if (gate_act) begin
                g1_d = (mode_q == MODE_COINC);
                st_d = ST_IDLE;
            end else if (win_last) begin
                g1_d = (mode_q == MODE_ANTI);
                st_d = ST_IDLE;
            end
        end
    end

    // State, captured settings and registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            mode_q   <= MODE_OFF;
            pol_q    <= 1'b1;
            g1_stb_o <= 1'b0;
            g2_stb_o <= 1'b0;
        end else begin
            st_q     <= st_d;
            g1_stb_o <= g1_d;
            g2_stb_o <= g2_d;
            if (load) begin
                mode_q <= mode_now;
                pol_q  <= pol_i;
            end
        end
    end

    // Pending flag.
    always_comb busy_o = (st_q == ST_WAIT);
endmodule

// File: rtl/coinc_gate_chk.sv
// Checker for coinc_gate_unit: port-level temporal properties.
module coinc_gate_chk #(
    parameter int WIN_W  = 8,
    parameter int LOST_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              store_i,
    input logic [2:0]        mode_i,
    input logic [WIN_W-1:0]  win_i,
    input logic              g1_stb_o,
    input logic              g2_stb_o,
    input logic              busy_o,
    input logic [LOST_W-1:0] lost_cnt_o
);
    localparam logic [LOST_W-1:0] CMAX = '1;

    // R2
    off_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_i && !busy_o && (mode_i == 3'd0 || mode_i > 3'd4)) |=> (g1_stb_o && !g2_stb_o));

    // R8
    comb_g2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_i && !busy_o && (mode_i == 3'd3 || mode_i == 3'd4)) |=> g2_stb_o);

    // R9
    g2_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        g2_stb_o |-> $past(store_i && !busy_o && (mode_i == 3'd3 || mode_i == 3'd4)));

    // R6
    zero_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_i && !busy_o && win_i == '0) |=> !busy_o);

    // R7
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (!g1_stb_o && !g2_stb_o));

    // R10
    lost_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && store_i && lost_cnt_o != CMAX) |=> (lost_cnt_o == $past(lost_cnt_o) + 1'b1));

    // R10
    lost_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_cnt_o == CMAX) |=> (lost_cnt_o == CMAX));
endmodule

bind coinc_gate_unit coinc_gate_chk #(.WIN_W(WIN_W), .LOST_W(LOST_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .store_i   (store_i),
    .mode_i    (mode_i),
    .win_i     (win_i),
    .g1_stb_o  (g1_stb_o),
    .g2_stb_o  (g2_stb_o),
    .busy_o    (busy_o),
    .lost_cnt_o(lost_cnt_o)
);

// File: tb/tb_coinc_gate_unit.sv
module tb_coinc_gate_unit;
    localparam int CLK_PER = 10;
    localparam int WIN_W   = 4;
    localparam int LOST_W  = 3;
    localparam int LMAX    = (1 << LOST_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              store_i = 1'b0;
    logic              gate_i = 1'b0;
    logic [2:0]        mode_i = 3'd0;
    logic              pol_i = 1'b1;
    logic [WIN_W-1:0]  win_i = '0;
    logic              g1_stb_o, g2_stb_o, busy_o;
    logic [LOST_W-1:0] lost_cnt_o;

    int n_chk = 0;
    int n_bad = 0;
    int exp_lost = 0;
    bit done = 1'b0;

    coinc_gate_unit #(.WIN_W(WIN_W), .LOST_W(LOST_W)) dut (
        .clk(clk), .rst_n(rst_n), .store_i(store_i), .gate_i(gate_i),
        .mode_i(mode_i), .pol_i(pol_i), .win_i(win_i),
        .g1_stb_o(g1_stb_o), .g2_stb_o(g2_stb_o), .busy_o(busy_o),
        .lost_cnt_o(lost_cnt_o)
    );

    always #(CLK_PER/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Outputs packed as {g1,g2,busy}
    task automatic check_outs(input string req, input int e1, input int e2, input int eb);
        check(req, {g1_stb_o, g2_stb_o, busy_o}, {e1[0], e2[0], eb[0]});
    endtask

    // One event: store at cycle 0, a one-cycle active gate at offset k (k<0: none).
    task automatic run_event(input int md, input int pl, input int w, input int k);
        int  d;
        bit  hit, comb, e1, e2;
        string req;
        comb = (md == 3 || md == 4);
        if (md == 1 || md == 2) begin
            hit = (k >= 0 && k <= w);
            d   = (w == 0) ? 0 : (hit ? k : w);
        end else begin
            hit = (k == 0);
            d   = 0;
        end
        case (md)
            1: begin e1 = hit;  req = (w == 0) ? "R6 coinc" : "R4 coinc"; end
            2: begin e1 = !hit; req = (w == 0) ? "R6 anti" : "R5 anti"; end
            3: begin e1 = hit;  req = "R8 comb-co"; end
            4: begin e1 = !hit; req = "R9 comb-anti"; end
            0: begin e1 = 1'b1; req = "R2 off"; end
            default: begin e1 = 1'b1; req = "R12 undef"; end
        endcase
        if (pl == 0) req = {req, " R3"};
        e2 = comb;
        for (int j = 0; j <= w + 2; j++) begin
            @(negedge clk);
            mode_i  = md[2:0];
            pol_i   = pl[0];
            win_i   = w[WIN_W-1:0];
            store_i = (j == 0);
            gate_i  = pl[0] ? (j == k) : !(j == k);
            @(posedge clk);
            #1;
            if (j == d) check_outs(req, e1, e2, 0);
            else if (j < d) check_outs({req, " R7"}, 0, 0, 1);
            else check_outs(req, 0, 0, 0);
        end
        @(negedge clk);
        store_i = 1'b0;
        gate_i  = !pl[0];
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check_outs("R1 reset", 0, 0, 0);
        check("R1 lost", lost_cnt_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_outs("R1 after", 0, 0, 0);

        // Sweep modes, polarities, windows and gate offsets.
        for (int md = 0; md < 8; md++)
            for (int pl = 0; pl < 2; pl++)
                for (int wi = 0; wi < 5; wi++) begin
                    int w;
                    w = (wi == 4) ? 5 : wi;
                    for (int k = -1; k <= w + 1; k++)
                        run_event(md, pl, w, k);
                end
        check("R10 no loss in sweep", lost_cnt_o, 0);

        // R11: settings changed while pending must not matter.
        @(negedge clk);
        mode_i = 3'd1; pol_i = 1'b1; win_i = 4'd3; gate_i = 1'b0; store_i = 1'b1;
        @(posedge clk);
        #1;
        check_outs("R11 start", 0, 0, 1);
        for (int j = 1; j <= 3; j++) begin
            @(negedge clk);
            store_i = 1'b0;
            mode_i = 3'd0; pol_i = 1'b0; win_i = '0; gate_i = 1'b0;
            @(posedge clk);
            #1;
            if (j < 3) check_outs("R11 hold", 0, 0, 1);
            else check_outs("R11 timeout", 0, 0, 0);
        end
        @(negedge clk);
        pol_i = 1'b1;

        // R10: stores while pending are dropped and counted, saturating.
        for (int rep = 0; rep < 3; rep++) begin
            for (int j = 0; j <= 4; j++) begin
                @(negedge clk);
                mode_i = 3'd1; pol_i = 1'b1; win_i = 4'd4; gate_i = 1'b0;
                store_i = 1'b1;
                if (j > 0 && exp_lost < LMAX) exp_lost++;
                @(posedge clk);
                #1;
                check("R10 no strobe", {g1_stb_o, g2_stb_o}, 0);
            end
            @(negedge clk);
            store_i = 1'b0;
            @(posedge clk);
            #1;
            check("R10 lost count", lost_cnt_o, exp_lost);
            check_outs("R10 idle", 0, 0, 0);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule